// File: doc/BRIEF.md
# Endpoint DMA Handshake Controller

This block lets an external DMA engine move bytes between the system bus and one endpoint buffer of a USB device controller. Software writes a configuration word that selects an endpoint index, a transfer direction, a byte count, a channel-sharing mode and an enable. While enabled, the block raises a request whenever the selected buffer can take part in a transfer. Each acknowledge strobe from the DMA engine moves exactly one byte through the simple buffer port.

A transfer ends when the programmed count runs out or when an external end-of-transfer pulse arrives. At that point the block drops its own enable and sends a one-cycle clear to the selected buffer, even if that buffer still holds unread bytes. Software must then arm both the DMA engine and this block again.

In shared-channel mode, the device request and acknowledge move onto the pin pair normally used by the host-side DMA channel. The dedicated device pins then stay idle. Endpoint indices 0 and 15 can never be DMA targets.

Top module: `epdma_ctrl`

## Requirements
- R1: A configuration write loads the endpoint index, direction, count and sharing mode, and the index reads back on `idx_o` from the next cycle on.
- R2: A configuration write that selects index 0 or index 15 leaves `en_o` at 0, so no request is ever raised for those indices.
- R3: The request is high only while enabled, and then exactly when `buf_has_data_i` is high (direction 1, IN, buffer to bus) or `buf_has_space_i` is high (direction 0, OUT, bus to buffer).
- R4: An acknowledge seen while the request is high moves one byte. In IN direction it pulses `buf_rd_o` and `bus_rdata_o` equals `buf_rdata_i`. In OUT direction it pulses `buf_wr_o` with `buf_wdata_o` equal to `bus_wdata_i`. An acknowledge seen while the request is low has no effect.
- R5: The acknowledge that consumes the last counted byte ends the transfer. In the next cycle `en_o` is 0 and `buf_clr_o` is high for exactly one cycle, with `buf_sel_o` equal to the selected index. A programmed count of 0 stands for 2^CNT_W bytes.
- R6: An `eot_i` pulse while enabled ends the transfer in the same way as R5. An `eot_i` pulse while disabled has no effect.
- R7: After a transfer ends, no request is raised until a new configuration write enables the block.
- R8: With sharing mode 1, the request drives `dreq_shr_o`, the acknowledge is taken from `dack_shr_i`, and `dreq_dev_o`, `dack_dev_i` and `host_dack_o` are idle or ignored. With sharing mode 0, the request drives `dreq_dev_o`, `host_dreq_i` passes to `dreq_shr_o`, and `dack_shr_i` passes to `host_dack_o`.
- R9: When a transfer ends in the same cycle as a configuration write, the end of transfer wins. The write is dropped and `en_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 4 | Endpoint index to target |
| cfg_en_i | input | 1 | Enable value written |
| cfg_dir_i | input | 1 | 1 = IN (buffer to bus), 0 = OUT (bus to buffer) |
| cfg_shared_i | input | 1 | 1 = use the shared handshake pins |
| cfg_count_i | input | CNT_W | Bytes to move (0 means 2^CNT_W) |
| en_o | output | 1 | Enable readback |
| idx_o | output | 4 | Index readback |
| eot_i | input | 1 | External end-of-transfer pulse |
| dreq_dev_o | output | 1 | Dedicated device DMA request |
| dack_dev_i | input | 1 | Dedicated device DMA acknowledge |
| dreq_shr_o | output | 1 | Request on the shared channel pins |
| dack_shr_i | input | 1 | Acknowledge on the shared channel pins |
| host_dreq_i | input | 1 | Host-side request to pass through |
| host_dack_o | output | 1 | Acknowledge passed to the host side |
| bus_wdata_i | input | DATA_W | Byte from the bus (OUT) |
| bus_rdata_o | output | DATA_W | Byte to the bus (IN) |
| buf_sel_o | output | 4 | Selected endpoint buffer |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | DATA_W | Buffer write data |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_rdata_i | input | DATA_W | Buffer read data |
| buf_clr_o | output | 1 | Buffer clear pulse |
| buf_has_data_i | input | 1 | Buffer holds at least one byte |
| buf_has_space_i | input | 1 | Buffer can accept one byte |

## Verification
The assertions check several rules on every cycle:
- a request only appears with a legal enabled index;
- every end of transfer is followed by a disabled state and a single clear pulse;
- the count falls by one per moved byte;
- read and write strobes never coincide;
- the dedicated request pin stays low in sharing mode.

Only the bench scenarios can show the rest. These cover the full sequences: counts running out with unread data left, `eot_i` arriving while enabled and while idle, a configuration write colliding with an end of transfer, and bytes and acknowledges reaching the right pins in both sharing modes.

// File: rtl/epdma_pkg.sv
package epdma_pkg;
  localparam int EP_IDX_W = 4;
  localparam logic [EP_IDX_W-1:0] EP_TOP = {EP_IDX_W{1'b1}};

  typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} dir_e;

  // an index may be served by DMA unless it is the lowest or highest one
  function automatic logic idx_dma_ok(input logic [EP_IDX_W-1:0] idx);
    return (idx != '0) && (idx != EP_TOP);
  endfunction

  // request condition for a given direction and buffer state
  function automatic logic want_xfer(input dir_e dir, input logic has_data,
                                     input logic has_space);
    return (dir == DIR_IN) ? has_data : has_space;
  endfunction
endpackage

// File: rtl/epdma_cfg.sv
module epdma_cfg
  import epdma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we_i,
  input  logic [EP_IDX_W-1:0] cfg_idx_i,
  input  logic                cfg_en_i,
  input  logic                cfg_dir_i,
  input  logic                cfg_shared_i,
  input  logic                term_i,
  output logic                load_o,
  output logic                en_q,
  output logic [EP_IDX_W-1:0] idx_q,
  output dir_e                dir_q,
  output logic                shared_q
);
  assign load_o = cfg_we_i && !term_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      idx_q    <= '0;
      dir_q    <= DIR_OUT;
      shared_q <= 1'b0;
    end else if (term_i) begin
      en_q <= 1'b0;
    end else if (cfg_we_i) begin
      en_q     <= cfg_en_i && idx_dma_ok(cfg_idx_i);
      idx_q    <= cfg_idx_i;
      dir_q    <= dir_e'(cfg_dir_i);
      shared_q <= cfg_shared_i;
    end
  end
endmodule

// File: rtl/epdma_count.sv
module epdma_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign last_o = (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= count_i;
    else if (step_i) cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/epdma_route.sv
module epdma_route (
  input  logic shared_i,
  input  logic req_i,
  output logic ack_o,
  output logic dreq_dev_o,
  input  logic dack_dev_i,
  output logic dreq_shr_o,
  input  logic dack_shr_i,
  input  logic host_dreq_i,
  output logic host_dack_o
);
  always_comb begin
    if (shared_i) begin
      dreq_dev_o  = 1'b0;
      dreq_shr_o  = req_i;
      ack_o       = dack_shr_i;
      host_dack_o = 1'b0;
    end else begin
      dreq_dev_o  = req_i;
      dreq_shr_o  = host_dreq_i;
      ack_o       = dack_dev_i;
      host_dack_o = dack_shr_i;
    end
  end
endmodule

// File: rtl/epdma_ctrl.sv
module epdma_ctrl
  import epdma_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we_i,
  input  logic [EP_IDX_W-1:0] cfg_idx_i,
  input  logic                cfg_en_i,
  input  logic                cfg_dir_i,
  input  logic                cfg_shared_i,
  input  logic [CNT_W-1:0]    cfg_count_i,
  output logic                en_o,
  output logic [EP_IDX_W-1:0] idx_o,
  input  logic                eot_i,
  output logic                dreq_dev_o,
  input  logic                dack_dev_i,
  output logic                dreq_shr_o,
  input  logic                dack_shr_i,
  input  logic                host_dreq_i,
  output logic                host_dack_o,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic [EP_IDX_W-1:0] buf_sel_o,
  output logic                buf_wr_o,
  output logic [DATA_W-1:0]   buf_wdata_o,
  output logic                buf_rd_o,
  input  logic [DATA_W-1:0]   buf_rdata_i,
  output logic                buf_clr_o,
  input  logic                buf_has_data_i,
  input  logic                buf_has_space_i
);
  // named internal events, observed by the bound checker
  logic                en_q, shared_q, load, ack, dev_req, xfer, last, term;
  logic [EP_IDX_W-1:0] idx_q;
  dir_e                dir_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                clr_q;

  epdma_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
    .cfg_en_i(cfg_en_i), .cfg_dir_i(cfg_dir_i), .cfg_shared_i(cfg_shared_i),
    .term_i(term), .load_o(load), .en_q(en_q), .idx_q(idx_q),
    .dir_q(dir_q), .shared_q(shared_q)
  );

  epdma_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load), .count_i(cfg_count_i),
    .step_i(xfer), .cnt_q(cnt_q), .last_o(last)
  );

  epdma_route u_route (
    .shared_i(shared_q), .req_i(dev_req), .ack_o(ack),
    .dreq_dev_o(dreq_dev_o), .dack_dev_i(dack_dev_i),
    .dreq_shr_o(dreq_shr_o), .dack_shr_i(dack_shr_i),
    .host_dreq_i(host_dreq_i), .host_dack_o(host_dack_o)
  );

  assign dev_req = en_q && want_xfer(dir_q, buf_has_data_i, buf_has_space_i);
  assign xfer    = dev_req && ack;
  assign term    = en_q && (eot_i || (xfer && last));

  // clear pulse lands in the cycle the enable reads back low
  always_ff @(posedge clk) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= term;
  end

  assign en_o        = en_q;
  assign idx_o       = idx_q;
  assign buf_sel_o   = idx_q;
  assign buf_clr_o   = clr_q;
  assign buf_rd_o    = xfer && (dir_q == DIR_IN);
  assign buf_wr_o    = xfer && (dir_q == DIR_OUT);
  assign buf_wdata_o = bus_wdata_i;
  assign bus_rdata_o = buf_rdata_i;
endmodule

// File: rtl/epdma_ctrl_chk.sv
module epdma_ctrl_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic [3:0]       idx_q,
  input logic             dev_req,
  input logic             xfer,
  input logic             term,
  input logic             cfg_we,
  input logic [CNT_W-1:0] cnt_q,
  input logic             buf_clr,
  input logic             buf_rd,
  input logic             buf_wr,
  input logic             dreq_dev,
  input logic             shared_q
);
  p_req_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> (en_q && idx_q != 4'd0 && idx_q != 4'd15));

  p_idx_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == 4'd0 || idx_q == 4'd15) |-> !en_q);

  p_end_disables_r5: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (!en_q && buf_clr));

  p_clr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clr |=> !buf_clr);

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !term && !cfg_we) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_rd, buf_wr}));

  p_dev_pin_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shared_q |-> !dreq_dev);

  p_idle_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cfg_we) |=> !en_q);
endmodule

bind epdma_ctrl epdma_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .idx_q(idx_q), .dev_req(dev_req),
  .xfer(xfer), .term(term), .cfg_we(cfg_we_i), .cnt_q(cnt_q),
  .buf_clr(buf_clr_o), .buf_rd(buf_rd_o), .buf_wr(buf_wr_o),
  .dreq_dev(dreq_dev_o), .shared_q(shared_q)
);

// File: tb/epdma_ctrl_test.sv
module epdma_ctrl_test;
  localparam int PERIOD = 10;
  localparam int CW = 12;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, cfg_dir = 0, cfg_sh = 0, eot = 0;
  logic [3:0] cfg_idx = 0;
  logic [CW-1:0] cfg_cnt = 0;
  logic dack_dev = 0, dack_shr = 0, host_dreq = 0, hd = 0, hs = 0;
  logic [DW-1:0] bus_wd = 0, buf_rd_data = 0;
  logic en_o, dreq_dev, dreq_shr, host_dack, buf_wr, buf_rd, buf_clr;
  logic [3:0] idx_o, buf_sel;
  logic [DW-1:0] bus_rd, buf_wd;

  int checks = 0, fails = 0;
  bit m_en = 0, m_dir = 0, m_sh = 0, m_clr = 0;
  logic [3:0] m_idx = 0;
  logic [CW-1:0] m_cnt = 0;
  string m_tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  epdma_ctrl #(.CNT_W(CW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_en_i(cfg_en), .cfg_dir_i(cfg_dir), .cfg_shared_i(cfg_sh),
    .cfg_count_i(cfg_cnt), .en_o(en_o), .idx_o(idx_o), .eot_i(eot),
    .dreq_dev_o(dreq_dev), .dack_dev_i(dack_dev), .dreq_shr_o(dreq_shr),
    .dack_shr_i(dack_shr), .host_dreq_i(host_dreq), .host_dack_o(host_dack),
    .bus_wdata_i(bus_wd), .bus_rdata_o(bus_rd), .buf_sel_o(buf_sel),
    .buf_wr_o(buf_wr), .buf_wdata_o(buf_wd), .buf_rd_o(buf_rd),
    .buf_rdata_i(buf_rd_data), .buf_clr_o(buf_clr),
    .buf_has_data_i(hd), .buf_has_space_i(hs)
  );

  function automatic bit legal(input logic [3:0] i);
    return i >= 4'd1 && i <= 4'd14;
  endfunction

  function automatic bit exp_req(input bit en, input bit dir, input bit d, input bit s);
    return en && (dir ? d : s);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle: check registered state, drive, check combinational, update model
  task automatic cyc(input bit we, input logic [3:0] idx, input bit en, input bit dir,
                     input bit sh, input logic [CW-1:0] cnt, input bit d, input bit s,
                     input bit ack, input bit e);
    bit req, xf, tm;
    @(negedge clk);
    chk(en_o == m_en, m_tag, en_o, m_en);
    chk(buf_clr == m_clr, "R5", buf_clr, m_clr);
    chk(idx_o == m_idx, "R1", idx_o, m_idx);
    if (m_clr) chk(buf_sel == m_idx, "R5", buf_sel, m_idx);
    cfg_we = we; cfg_idx = idx; cfg_en = en; cfg_dir = dir; cfg_sh = sh; cfg_cnt = cnt;
    hd = d; hs = s; eot = e;
    host_dreq = 1'($urandom); bus_wd = 8'($urandom); buf_rd_data = 8'($urandom);
    if (m_sh) begin dack_shr = ack; dack_dev = 1'($urandom); end
    else      begin dack_dev = ack; dack_shr = 1'($urandom); end
    #1;
    req = exp_req(m_en, m_dir, d, s);
    xf  = req && ack;
    tm  = m_en && (e || (xf && m_cnt == 1));
    if (m_sh) begin
      chk(dreq_shr == req, "R8", dreq_shr, req);
      chk(dreq_dev == 0, "R8", dreq_dev, 0);
      chk(host_dack == 0, "R8", host_dack, 0);
    end else begin
      chk(dreq_dev == req, "R3", dreq_dev, req);
      chk(dreq_shr == host_dreq, "R8", dreq_shr, host_dreq);
      chk(host_dack == dack_shr, "R8", host_dack, dack_shr);
    end
    chk(buf_rd == (xf && m_dir), "R4", buf_rd, xf && m_dir);
    chk(buf_wr == (xf && !m_dir), "R4", buf_wr, xf && !m_dir);
    if (xf && m_dir)  chk(bus_rd == buf_rd_data, "R4", bus_rd, buf_rd_data);
    if (xf && !m_dir) chk(buf_wd == bus_wd, "R4", buf_wd, bus_wd);
    @(posedge clk);
    m_clr = tm;
    if (tm) begin
      m_en = 0;
      m_tag = we ? "R9" : (e ? "R6" : "R5");
    end else if (we) begin
      m_en = en && legal(idx); m_idx = idx; m_dir = dir; m_sh = sh; m_cnt = cnt;
      m_tag = legal(idx) ? "R1" : "R2";
    end else begin
      if (xf) m_cnt = m_cnt - 1;
      if (!m_en) m_tag = "R7";
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(en_o == 0, "R1", en_o, 0);
    chk(buf_clr == 0, "R5", buf_clr, 0);
    chk(dreq_dev == 0, "R3", dreq_dev, 0);
    rst_n = 1;
    // R2: illegal indices never arm the block
    cyc(1, 4'd0, 1, 1, 0, 12'd4, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 1, 0);
    cyc(1, 4'd15, 1, 0, 0, 12'd4, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 1, 0);
    // R5: IN, count 3; R4 ack with no data is ignored; buffer still has data at end
    cyc(1, 4'd3, 1, 1, 0, 12'd3, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 1, 0);   // R7: no request after end
    // R6: OUT, end by pulse after two bytes
    cyc(1, 4'd5, 1, 0, 0, 12'd10, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 1);   // R6: pulse while idle
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R8: shared mode transfer
    cyc(1, 4'd7, 1, 1, 1, 12'd2, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 0, 1, 1, 1, 0);
    // R9: configuration write collides with the final byte
    cyc(1, 4'd2, 1, 0, 0, 12'd1, 0, 0, 0, 0);
    cyc(1, 4'd9, 1, 1, 1, 12'd5, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 1, 0);
    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit we;
      we = (!m_en && ($urandom_range(2) == 0)) || ($urandom_range(39) == 0);
      cyc(we, 4'($urandom), $urandom_range(7) != 0, 1'($urandom), 1'($urandom),
          CW'($urandom_range(6, 1)), 1'($urandom), 1'($urandom), 1'($urandom),
          $urandom_range(29) == 0);
    end
    @(negedge clk);
    chk(en_o == m_en, m_tag, en_o, m_en);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule